// File: doc/BRIEF.md
# Indexed PLL Configuration Register Bank

This block is the register-side control for a group of up to eight PLL channels that all sit behind one small register window. An update register carries a channel selector; the two control words seen on the bus always belong to the selected channel. Bus writes to the control words only land in a per-channel staging copy. Nothing reaches the PLL until software writes the update register with its commit bit set and a channel id. That copies the channel's staged words into its active settings.

Every commit drops the channel's ready flag. If the committed settings keep the PLL enabled, a per-channel down-counter loaded from the startup field, scaled by a fixed prescaler, brings the flag back once it reaches zero. If the PLL is disabled, the flag stays low. The active divider, multiplier, fractional part and enable bits are driven out per channel for the analog macro, which is outside this block.

Top module: `pll_cfg_bank`

## Requirements
- R1: Word address 0 is control word 0 and word address 1 is control word 1 of the selected channel. Control word 0 has the divider in bits 7:0, divider enable in bit 8, lock enable in bit 9 and PLL enable in bit 10. Control word 1 has the multiplier in bits 31:24 and the fraction in bits 21:0. A read returns the staged value on `bus_rdata` one clock after the read is presented. Unused bits read 0.
- R2: A write to a control word changes only the staging copy. The active outputs do not change until a commit.
- R3: A write to word address 2 with bit 8 set commits the staged words of the channel named in bits 2:0 to that channel's active outputs. The outputs show the new values after the second rising edge counted from the write edge.
- R4: Word address 2 reads back the channel selector in bits 2:0 and the startup field in bits 21:16. Bit 8, the commit bit, always reads 0.
- R5: After a commit with PLL enable set, the channel's ready flag is 0 after the next edge. It is 1 again exactly STARTUP*PRESCALE+2 rising edges after the write edge; a startup value of 0 gives 2 edges.
- R6: After a commit with PLL enable clear, the channel's ready flag is 0 and stays 0.
- R7: Word address 3 reads the ready flags, bit n for channel n. Bits at or above the channel count read 0.
- R8: While the selector names an id at or above the channel count, control-word writes change no channel, reads of the control words return 0, and a commit changes nothing.
- R9: A commit to one channel leaves the active settings and ready flags of every other channel unchanged.
- R10: After reset, all staged and active settings are 0, the selector is 0 and all ready flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| ready_o | output | NUM_CH | Per-channel ready flag |
| pll_en_o | output | NUM_CH | Active PLL enable per channel |
| div_en_o | output | NUM_CH | Active divider enable per channel |
| lock_en_o | output | NUM_CH | Active lock enable per channel |
| div_o | output | NUM_CH*8 | Active output dividers, channel n in bits 8n+7:8n |
| mul_o | output | NUM_CH*8 | Active multipliers, channel n in bits 8n+7:8n |
| frac_o | output | NUM_CH*22 | Active fractions, channel n in bits 22n+21:22n |

## Verification
The commit path is checked with directed sequences and with random full-width control words on random channels. The random words catch swapped or truncated field positions and show whether a commit reaches only its own channel. Relock timing is measured edge by edge with startup values 0 and 5, which separates off-by-one errors in the counter load from prescaler errors. A disable commit is checked to keep the flag low. The id that is one above the last channel and the largest id are used to confirm that writes, reads and commits through an unimplemented slot touch nothing.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

   localparam int BUS_W     = 32;
   localparam int DIV_W     = 8;
   localparam int MUL_W     = 8;
   localparam int FRAC_W    = 22;
   localparam int ID_W      = 3;
   localparam int STUP_W    = 6;
   localparam int MAX_CH    = 1 << ID_W;

   // control word 0 layout
   localparam int C0_DIVEN_BIT  = 8;
   localparam int C0_LOCKEN_BIT = 9;
   localparam int C0_PLLEN_BIT  = 10;
   // control word 1 layout
   localparam int C1_MUL_LSB    = 24;
   // update word layout
   localparam int UP_GO_BIT     = 8;
   localparam int UP_STUP_LSB   = 16;

   typedef enum logic [1:0] {
      RA_CTL0 = 2'd0,
      RA_CTL1 = 2'd1,
      RA_UPD  = 2'd2,
      RA_STAT = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic             pll_en;
      logic             lock_en;
      logic             div_en;
      logic [DIV_W-1:0] div;
   } ctl0_t;

   typedef struct packed {
      logic [MUL_W-1:0]  mul;
      logic [FRAC_W-1:0] frac;
   } ctl1_t;

   function automatic logic [BUS_W-1:0] enc_ctl0(input ctl0_t c);
      logic [BUS_W-1:0] w;
      w = '0;
      w[DIV_W-1:0]     = c.div;
      w[C0_DIVEN_BIT]  = c.div_en;
      w[C0_LOCKEN_BIT] = c.lock_en;
      w[C0_PLLEN_BIT]  = c.pll_en;
      return w;
   endfunction

   function automatic logic [BUS_W-1:0] enc_ctl1(input ctl1_t c);
      logic [BUS_W-1:0] w;
      w = '0;
      w[FRAC_W-1:0]                  = c.frac;
      w[C1_MUL_LSB +: MUL_W]         = c.mul;
      return w;
   endfunction

endpackage

// File: rtl/pll_cfg_chan.sv
module pll_cfg_chan
   import pll_cfg_pkg::*;
#(
   parameter int PRESCALE = 16
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_ctl0_i,
   input  logic                 wr_ctl1_i,
   input  logic                 commit_i,
   input  logic [BUS_W-1:0]     wdata_i,
   input  logic [STUP_W-1:0]    stup_i,
   output ctl0_t                stg0_o,
   output ctl1_t                stg1_o,
   output ctl0_t                act0_o,
   output ctl1_t                act1_o,
   output logic                 ready_o
);

   localparam int MAX_WAIT = ((1 << STUP_W) - 1) * PRESCALE;
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   ctl0_t            stg0_q, act0_q, wr0;
   ctl1_t            stg1_q, act1_q, wr1;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             ready_q;
   logic             unused_wd;

   assign unused_wd = ^wdata_i[C1_MUL_LSB-1:FRAC_W];

   // field extraction from the bus word
   always_comb begin
      wr0.div     = wdata_i[DIV_W-1:0];
      wr0.div_en  = wdata_i[C0_DIVEN_BIT];
      wr0.lock_en = wdata_i[C0_LOCKEN_BIT];
      wr0.pll_en  = wdata_i[C0_PLLEN_BIT];
      wr1.frac    = wdata_i[FRAC_W-1:0];
      wr1.mul     = wdata_i[C1_MUL_LSB +: MUL_W];
   end

   // staging copy, written by the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg0_q <= '0;
         stg1_q <= '0;
      end else begin
         if (wr_ctl0_i) stg0_q <= wr0;
         if (wr_ctl1_i) stg1_q <= wr1;
      end
   end

   // active copy and relock timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act0_q  <= '0;
         act1_q  <= '0;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
      end else if (commit_i) begin
         act0_q  <= stg0_q;
         act1_q  <= stg1_q;
         ready_q <= 1'b0;
         busy_q  <= stg0_q.pll_en;
         cnt_q   <= CNT_W'(stup_i) * CNT_W'(PRESCALE);
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            ready_q <= 1'b1;
            busy_q  <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign stg0_o  = stg0_q;
   assign stg1_o  = stg1_q;
   assign act0_o  = act0_q;
   assign act1_o  = act1_q;
   assign ready_o = ready_q;

   p_commit_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> !ready_o);

   p_off_never_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !act0_q.pll_en |-> !ready_o);

   p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> ($stable(act0_q) && $stable(act1_q)));

   p_ready_after_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> ($past(busy_q) && $past(cnt_q) == '0));

endmodule

// File: rtl/pll_cfg_regif.sv
module pll_cfg_regif
   import pll_cfg_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter bit RDATA_REG = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel_i,
   input  logic                 bus_we_i,
   input  logic [1:0]           bus_addr_i,
   input  logic [BUS_W-1:0]     bus_wdata_i,
   output logic [BUS_W-1:0]     bus_rdata_o,
   input  ctl0_t [NUM_CH-1:0]   stg0_i,
   input  ctl1_t [NUM_CH-1:0]   stg1_i,
   input  logic [NUM_CH-1:0]    ready_i,
   output logic [NUM_CH-1:0]    wr_ctl0_o,
   output logic [NUM_CH-1:0]    wr_ctl1_o,
   output logic [NUM_CH-1:0]    commit_o,
   output logic [STUP_W-1:0]    stup_o
);

   logic [ID_W-1:0]   sel_id_q;
   logic [ID_W-1:0]   upd_id_q;
   logic [STUP_W-1:0] stup_q;
   logic              upd_pulse_q;
   logic              id_ok;
   logic              wr_en;
   logic              rd_en;
   logic [BUS_W-1:0]  rd_mux;
   logic              unused_wd;

   assign unused_wd = ^{bus_wdata_i[BUS_W-1:UP_STUP_LSB+STUP_W],
                        bus_wdata_i[UP_STUP_LSB-1:UP_GO_BIT+1],
                        bus_wdata_i[UP_GO_BIT-1:ID_W]};

   assign wr_en = bus_sel_i &  bus_we_i;
   assign rd_en = bus_sel_i & ~bus_we_i;
   assign id_ok = (int'(sel_id_q) < NUM_CH);

   // update register: selector, startup field, self-clearing commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_id_q    <= '0;
         upd_id_q    <= '0;
         stup_q      <= '0;
         upd_pulse_q <= 1'b0;
      end else if (wr_en && bus_addr_i == RA_UPD) begin
         sel_id_q    <= bus_wdata_i[ID_W-1:0];
         upd_id_q    <= bus_wdata_i[ID_W-1:0];
         stup_q      <= bus_wdata_i[UP_STUP_LSB +: STUP_W];
         upd_pulse_q <= bus_wdata_i[UP_GO_BIT];
      end else begin
         upd_pulse_q <= 1'b0;
      end
   end

   // per-channel strobes
   for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
      assign wr_ctl0_o[c] = wr_en && bus_addr_i == RA_CTL0 && id_ok
                            && sel_id_q == ID_W'(c);
      assign wr_ctl1_o[c] = wr_en && bus_addr_i == RA_CTL1 && id_ok
                            && sel_id_q == ID_W'(c);
      assign commit_o[c]  = upd_pulse_q && upd_id_q == ID_W'(c);
   end

   assign stup_o = stup_q;

   // read multiplexer
   always_comb begin
      rd_mux = '0;
      unique case (bus_addr_i)
         RA_CTL0: if (id_ok) rd_mux = enc_ctl0(stg0_i[sel_id_q]);
         RA_CTL1: if (id_ok) rd_mux = enc_ctl1(stg1_i[sel_id_q]);
         RA_UPD: begin
            rd_mux[ID_W-1:0]               = sel_id_q;
            rd_mux[UP_STUP_LSB +: STUP_W]  = stup_q;
         end
         default: rd_mux[NUM_CH-1:0] = ready_i;
      endcase
   end

   if (RDATA_REG) begin : g_rd_flop
      logic [BUS_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata_q <= '0;
         else if (rd_en) rdata_q <= rd_mux;
      end
      assign bus_rdata_o = rdata_q;

      p_go_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && bus_addr_i == RA_UPD) |=> !bus_rdata_o[UP_GO_BIT]);

      p_bad_id_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && bus_addr_i != RA_UPD && bus_addr_i != RA_STAT
          && int'(sel_id_q) >= NUM_CH) |=> bus_rdata_o == '0);
   end else begin : g_rd_comb
      assign bus_rdata_o = rd_mux;
   end

   p_pulse_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse_q |-> $past(wr_en && bus_addr_i == RA_UPD && bus_wdata_i[UP_GO_BIT]));

endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
   import pll_cfg_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int PRESCALE  = 16,
   parameter bit RDATA_REG = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_we,
   input  logic [1:0]               bus_addr,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic [NUM_CH-1:0]        ready_o,
   output logic [NUM_CH-1:0]        pll_en_o,
   output logic [NUM_CH-1:0]        div_en_o,
   output logic [NUM_CH-1:0]        lock_en_o,
   output logic [NUM_CH*8-1:0]      div_o,
   output logic [NUM_CH*8-1:0]      mul_o,
   output logic [NUM_CH*22-1:0]     frac_o
);

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("pll_cfg_bank: NUM_CH out of range");
   end
   if (PRESCALE < 1) begin : g_bad_pre
      $error("pll_cfg_bank: PRESCALE must be at least 1");
   end

   ctl0_t [NUM_CH-1:0] stg0, act0;
   ctl1_t [NUM_CH-1:0] stg1, act1;
   logic  [NUM_CH-1:0] wr_ctl0, wr_ctl1, commit, ready;
   logic  [STUP_W-1:0] stup;

   pll_cfg_regif #(
      .NUM_CH    (NUM_CH),
      .RDATA_REG (RDATA_REG)
   ) regif_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel_i   (bus_sel),
      .bus_we_i    (bus_we),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .stg0_i      (stg0),
      .stg1_i      (stg1),
      .ready_i     (ready),
      .wr_ctl0_o   (wr_ctl0),
      .wr_ctl1_o   (wr_ctl1),
      .commit_o    (commit),
      .stup_o      (stup)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pll_cfg_chan #(
         .PRESCALE (PRESCALE)
      ) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_ctl0_i (wr_ctl0[c]),
         .wr_ctl1_i (wr_ctl1[c]),
         .commit_i  (commit[c]),
         .wdata_i   (bus_wdata),
         .stup_i    (stup),
         .stg0_o    (stg0[c]),
         .stg1_o    (stg1[c]),
         .act0_o    (act0[c]),
         .act1_o    (act1[c]),
         .ready_o   (ready[c])
      );

      assign pll_en_o[c]          = act0[c].pll_en;
      assign div_en_o[c]          = act0[c].div_en;
      assign lock_en_o[c]         = act0[c].lock_en;
      assign div_o[c*8 +: 8]      = act0[c].div;
      assign mul_o[c*8 +: 8]      = act1[c].mul;
      assign frac_o[c*22 +: 22]   = act1[c].frac;
   end

   assign ready_o = ready;

   p_one_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit));

   p_ctl_write_one_ch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_ctl0 | wr_ctl1));

endmodule

// File: tb/pll_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module pll_cfg_bank_tb_top;

   localparam int NCH = 6;
   localparam int PRE = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    ready_o, pll_en_o, div_en_o, lock_en_o;
   logic [NCH*8-1:0]  div_o, mul_o;
   logic [NCH*22-1:0] frac_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_stg0 [8];
   logic [31:0] m_stg1 [8];
   logic [31:0] m_act0 [8];
   logic [31:0] m_act1 [8];
   logic        m_rdy  [8];
   int          m_sel = 0;
   int          m_stup = 0;

   always #2.5 clk = ~clk;

   pll_cfg_bank #(.NUM_CH(NCH), .PRESCALE(PRE)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ready_o(ready_o), .pll_en_o(pll_en_o), .div_en_o(div_en_o),
      .lock_en_o(lock_en_o), .div_o(div_o), .mul_o(mul_o), .frac_o(frac_o));

   function automatic int relock_edges(int stup);
      return stup * PRE + 2;
   endfunction

   function automatic logic [31:0] exp_ctl(int which);
      if (m_sel >= NCH) return 32'h0;
      return (which == 0) ? m_stg0[m_sel] : m_stg1[m_sel];
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic upd(input int id, input int stup, input bit go);
      bus_wr(2'd2, (32'(stup) << 16) | (32'(go) << 8) | 32'(id));
      m_sel = id; m_stup = stup;
      if (go && id < NCH) begin
         m_act0[id] = m_stg0[id];
         m_act1[id] = m_stg1[id];
         m_rdy[id]  = 1'b0;
      end
   endtask

   task automatic wr_c0(input logic [31:0] d);
      bus_wr(2'd0, d);
      if (m_sel < NCH) m_stg0[m_sel] = d & 32'h0000_07FF;
   endtask

   task automatic wr_c1(input logic [31:0] d);
      bus_wr(2'd1, d);
      if (m_sel < NCH) m_stg1[m_sel] = d & 32'hFF3F_FFFF;
   endtask

   task automatic settle(input int id);
      repeat (relock_edges(m_stup) + 2) @(negedge clk);
      if (id < NCH) m_rdy[id] = m_act0[id][10];
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < NCH; c++) begin
         check(req, $sformatf("ch%0d div", c),   64'(div_o[c*8 +: 8]),    64'(m_act0[c][7:0]));
         check(req, $sformatf("ch%0d en", c),
               64'({pll_en_o[c], lock_en_o[c], div_en_o[c]}), 64'(m_act0[c][10:8]));
         check(req, $sformatf("ch%0d mul", c),   64'(mul_o[c*8 +: 8]),    64'(m_act1[c][31:24]));
         check(req, $sformatf("ch%0d frac", c),  64'(frac_o[c*22 +: 22]), 64'(m_act1[c][21:0]));
         check(req, $sformatf("ch%0d ready", c), 64'(ready_o[c]),         64'(m_rdy[c]));
      end
   endtask

   task automatic check_readback(input string req);
      logic [31:0] d;
      bus_rd(2'd0, d); check(req, "ctl0 read", 64'(d), 64'(exp_ctl(0)));
      bus_rd(2'd1, d); check(req, "ctl1 read", 64'(d), 64'(exp_ctl(1)));
   endtask

   task automatic measure(input int id, input int stup, input string req);
      int first;
      first = -1;
      upd(id, stup, 1'b1);
      for (int n = 1; n <= relock_edges(stup) + 3; n++) begin
         @(negedge clk);
         if (n == 1) check(req, "ready cleared after commit", 64'(ready_o[id]), 64'(0));
         if (ready_o[id] && first < 0) first = n;
      end
      check(req, $sformatf("relock edges stup=%0d", stup), 64'(first), 64'(relock_edges(stup)));
      m_rdy[id] = 1'b1;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(5.0 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int c = 0; c < 8; c++) begin
         m_stg0[c] = '0; m_stg1[c] = '0; m_act0[c] = '0; m_act1[c] = '0; m_rdy[c] = 1'b0;
      end
      void'($urandom(32'h1F2E_3D4C));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      check_all("R10");
      bus_rd(2'd3, d); check("R10", "status after reset", 64'(d), 64'(0));
      bus_rd(2'd2, d); check("R10", "update reg after reset", 64'(d), 64'(0));
      check_readback("R10");

      // R1 / R2: staging on channel 2
      upd(2, 5, 1'b0);
      wr_c0(32'hFFFF_F5A3);
      wr_c1(32'hFFFF_FFFF);
      check_readback("R1");
      repeat (3) @(negedge clk);
      check_all("R2");

      // R4: update register read-back
      bus_rd(2'd2, d); check("R4", "update read", 64'(d), 64'((32'd5 << 16) | 32'd2));

      // R5 / R3: commit and exact relock timing
      measure(2, 5, "R5");
      check_all("R3");
      bus_rd(2'd2, d); check("R4", "commit bit reads 0", 64'(d[8]), 64'(0));
      bus_rd(2'd3, d); check("R7", "status", 64'(d), 64'(32'h4));

      // R5 corner: startup 0 on channel 0
      upd(0, 0, 1'b0);
      wr_c0(32'h0000_0401);
      measure(0, 0, "R5");
      check_all("R9");
      bus_rd(2'd3, d); check("R7", "status two ready", 64'(d), 64'(32'h5));

      // R6: disable channel 2
      upd(2, 1, 1'b0);
      wr_c0(32'h0000_0123);
      upd(2, 1, 1'b1);
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         if (n == 0 || n == 19)
            check("R6", "ready after disable", 64'(ready_o[2]), 64'(0));
      end
      m_rdy[2] = 1'b0;
      check_all("R6");

      // R8: ids at and above the channel count
      for (int id = NCH; id < 8; id += 8 - NCH - 1) begin
         upd(id, 0, 1'b0);
         wr_c0(32'h0000_07FF);
         wr_c1(32'hFFFF_FFFF);
         check_readback("R8");
         upd(id, 0, 1'b1);
         settle(id);
         check_all("R8");
         if (id == 7) break;
      end
      for (int c = 0; c < NCH; c++) begin
         upd(c, 0, 1'b0);
         check_readback("R8");
      end

      // random traffic: R1, R3, R5, R9
      for (int it = 0; it < 40; it++) begin
         int ch;
         int st;
         ch = $urandom_range(0, NCH - 1);
         st = $urandom_range(0, 3);
         upd(ch, st, 1'b0);
         wr_c0($urandom);
         if ($urandom_range(0, 1) == 1) wr_c1($urandom);
         check_readback("R1");
         if ($urandom_range(0, 3) != 0) begin
            upd(ch, st, 1'b1);
            settle(ch);
            check_all("R9");
         end else begin
            repeat (2) @(negedge clk);
            check_all("R2");
         end
      end
      bus_rd(2'd3, d);
      begin
         logic [31:0] e;
         e = '0;
         for (int c = 0; c < NCH; c++) e[c] = m_rdy[c];
         check("R7", "status after random", 64'(d), 64'(e));
      end

      summary();
      $finish;
   end

endmodule